// File: doc/BRIEF.md
# Dual-Clock Audio Sample Playback Buffer

This block stores a ring of 1024 signed 16-bit audio samples and plays them out one per step of a slow sample clock. A producer on a separate, much faster clock loads the store one byte at a time through a byte-addressed port. A consumer on the sample clock starts and stops playback and picks a playback rate. The block drives a `playing` level, the current 16-bit sample, and a half flag.

The half flag tells the producer which half of the ring the reader is in: the lower 512 samples or the upper 512. The producer refills the other half while the reader drains this one. This gives double-buffered streaming without a handshake. The flag changes in the sample-clock domain, so the producer must pass it through its own synchroniser.

Top module: `pcm_playback_buf`

## Requirements
- R1: A synchronous reset on `rd_clk` leaves `playing` at 0, `half` at 0, `sample` at 0, and the read pointer at sample 0.
- R2: If `play` is 1 and `stop` is 0 at an `rd_clk` edge while idle, `playing` is 1 after that edge, and playback begins at sample 0.
- R3: If `stop` is 1 at an `rd_clk` edge, `playing` is 0 after that edge and the read pointer returns to 0. `stop` wins over a simultaneous `play`.
- R4: While `playing` is 0, `sample` is 0.
- R5: The store read takes one cycle. On the edge after the one that raised `playing`, `sample` shows sample 0.
- R6: A write with `wr_en` = 1 places `wr_data` into byte `wr_addr`. Byte address 2*i is the low byte of sample i and 2*i+1 is its high byte. A write with `wr_en` = 0 changes nothing.
- R7: `speed` = 2'd2 advances the read pointer by two samples per cycle. `speed` = 2'd1 and 2'd3 both advance it by one.
- R8: `speed` = 2'd0 holds the read pointer, so the same sample repeats on every cycle.
- R9: While playing, the read pointer wraps from 1023 to 0 and playback continues.
- R10: `half` equals bit 9 of the read pointer. It is 1 exactly while the pointer is in samples 512 to 1023.
- R11: Samples rewritten through the write port in the half not being read appear in the output on the next pass over that half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rd_clk | input | 1 | Sample clock for the reader side |
| rst | input | 1 | Synchronous reset, active high, on `rd_clk` |
| play | input | 1 | Start playback |
| stop | input | 1 | Stop playback and rewind |
| speed | input | 2 | Rate: 0 pause, 1 normal, 2 double, 3 normal |
| playing | output | 1 | Playback active |
| half | output | 1 | Reader is in the upper half of the ring |
| sample | output | 16 | Current output sample |
| wr_clk | input | 1 | Writer clock, asynchronous to and faster than `rd_clk` |
| wr_en | input | 1 | Byte write enable |
| wr_addr | input | 11 | Byte address |
| wr_data | input | 8 | Byte to write |

## Verification
The hardest case to reach is the ping-pong refill. New data has to be written into the lower half while the reader is in the upper half, and it has to be seen only after the pointer wraps. To get there, the stimulus runs normal-speed playback for more than a full lap. A concurrent writer waits for `half` to rise and then rewrites all 512 lower samples with a second pattern. The write port is about four times faster than the read side, so the refill finishes long before the wrap. The expected queue then predicts the new values for the second pass.

// File: rtl/pbuf_pkg.sv
`timescale 1ns/100ps
package pbuf_pkg;

  typedef enum logic [1:0] {
    SPD_HOLD = 2'd0,
    SPD_X1   = 2'd1,
    SPD_X2   = 2'd2,
    SPD_ALT  = 2'd3
  } spd_e;

  // Pointer increment selected by the rate input.
  function automatic logic [1:0] step_of(input logic [1:0] spd);
    case (spd_e'(spd))
      SPD_HOLD: return 2'd0;
      SPD_X2:   return 2'd2;
      default:  return 2'd1;
    endcase
  endfunction

endpackage

// File: rtl/pbuf_ram.sv
`timescale 1ns/100ps
module pbuf_ram #(
  parameter int DEPTH  = 1024,
  parameter int BYTE_W = 8,
  parameter int LANES  = 2,
  localparam int AW    = $clog2(DEPTH),
  localparam int LSW   = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int WAW   = AW + LSW
) (
  input  logic                    wr_clk,
  input  logic                    wr_en,
  input  logic [WAW-1:0]          wr_addr,
  input  logic [BYTE_W-1:0]       wr_data,
  input  logic                    rd_clk,
  input  logic [AW-1:0]           rd_addr,
  output logic [LANES*BYTE_W-1:0] rd_data
);

  logic [AW-1:0]  wr_row;
  logic [LSW-1:0] wr_lane;
  assign wr_row  = wr_addr[WAW-1:LSW];
  assign wr_lane = wr_addr[LSW-1:0];

  // One byte-wide array per lane, each with its own write strobe.
  for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
    logic [BYTE_W-1:0] store [DEPTH];
    logic lane_we;
    assign lane_we = wr_en && (wr_lane == LSW'(ln));

    always_ff @(posedge wr_clk) begin
      if (lane_we) store[wr_row] <= wr_data;
    end

    always_ff @(posedge rd_clk) begin
      rd_data[ln*BYTE_W +: BYTE_W] <= store[rd_addr];
    end
  end

endmodule

// File: rtl/pbuf_seq.sv
`timescale 1ns/100ps
module pbuf_seq #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          play,
  input  logic          stop,
  input  logic [1:0]    speed,
  output logic          run_o,
  output logic [AW-1:0] addr_o,
  output logic          show_o
);
  import pbuf_pkg::*;

  logic          run_q, show_q;
  logic [AW-1:0] addr_q;
  logic          run_nx;
  logic [AW-1:0] step;

  // Named events for the checks below.
  logic start_evt, stop_evt, adv_evt, wrap_evt;

  assign run_nx    = stop ? 1'b0 : (run_q | play);
  assign start_evt = !run_q && run_nx;
  assign stop_evt  = run_q && !run_nx;
  assign adv_evt   = run_q && run_nx;
  assign step      = AW'(step_of(speed));
  assign wrap_evt  = adv_evt && (({1'b0, addr_q} + {1'b0, step}) >> AW) != 0;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= 1'b0;
      show_q <= 1'b0;
      addr_q <= '0;
    end else begin
      run_q  <= run_nx;
      show_q <= adv_evt;
      addr_q <= adv_evt ? addr_q + step : '0;
    end
  end

  assign run_o  = run_q;
  assign addr_o = addr_q;
  assign show_o = show_q;

  assert_start_R2: assert property (@(posedge clk) disable iff (rst)
    (!run_q && play && !stop) |=> (run_q && addr_q == '0));

  assert_stop_R3: assert property (@(posedge clk) disable iff (rst)
    stop |=> (!run_q && addr_q == '0));

  assert_pause_R8: assert property (@(posedge clk) disable iff (rst)
    (adv_evt && speed == 2'd0) |=> $stable(addr_q));

  assert_wrap_R9: assert property (@(posedge clk) disable iff (rst)
    (adv_evt && speed == 2'd1 && addr_q == '1) |=> (addr_q == '0));

  assert_rewind_R3: assert property (@(posedge clk) disable iff (rst)
    stop_evt |=> !show_q);

  assert_enter_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(run_q) |-> (addr_q == '0 && !show_q));

  logic unused_evt;
  assign unused_evt = start_evt ^ wrap_evt;

endmodule

// File: rtl/pcm_playback_buf.sv
`timescale 1ns/100ps
module pcm_playback_buf #(
  parameter int SAMPLES  = 1024,
  parameter int SAMPLE_W = 16,
  parameter int BYTE_W   = 8,
  localparam int AW      = $clog2(SAMPLES),
  localparam int LANES   = SAMPLE_W / BYTE_W,
  localparam int LSW     = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int WAW     = AW + LSW
) (
  input  logic                rd_clk,
  input  logic                rst,
  input  logic                play,
  input  logic                stop,
  input  logic [1:0]          speed,
  output logic                playing,
  output logic                half,
  output logic [SAMPLE_W-1:0] sample,
  input  logic                wr_clk,
  input  logic                wr_en,
  input  logic [WAW-1:0]      wr_addr,
  input  logic [BYTE_W-1:0]   wr_data
);

  logic                run_w, show_w;
  logic [AW-1:0]       ptr_w;
  logic [SAMPLE_W-1:0] ram_q;

  pbuf_seq #(.AW(AW)) u_seq (
    .clk    (rd_clk),
    .rst    (rst),
    .play   (play),
    .stop   (stop),
    .speed  (speed),
    .run_o  (run_w),
    .addr_o (ptr_w),
    .show_o (show_w)
  );

  pbuf_ram #(.DEPTH(SAMPLES), .BYTE_W(BYTE_W), .LANES(LANES)) u_ram (
    .wr_clk  (wr_clk),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_clk  (rd_clk),
    .rd_addr (ptr_w),
    .rd_data (ram_q)
  );

  assign playing = run_w;
  assign half    = ptr_w[AW-1];
  assign sample  = show_w ? ram_q : '0;

  assert_idle_zero_R4: assert property (@(posedge rd_clk) disable iff (rst)
    !playing |-> (sample == '0));

  assert_half_lo_R10: assert property (@(posedge rd_clk) disable iff (rst)
    !playing |-> !half);

endmodule

// File: tb/sim_pcm_playback_buf.sv
`timescale 1ns/100ps
module sim_pcm_playback_buf;

  logic        rd_clk = 1'b0, wr_clk = 1'b0;
  logic        rst = 1'b1, play = 1'b0, stop = 1'b0;
  logic [1:0]  speed = 2'd1;
  logic        playing, half;
  logic [15:0] sample;
  logic        wr_en = 1'b0;
  logic [10:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;

  always #2   rd_clk = ~rd_clk;   // 250 MHz sample side
  always #0.5 wr_clk = ~wr_clk;   // faster writer side

  pcm_playback_buf u0 (
    .rd_clk(rd_clk), .rst(rst), .play(play), .stop(stop), .speed(speed),
    .playing(playing), .half(half), .sample(sample),
    .wr_clk(wr_clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  int vectors = 0, miscompares = 0;
  logic [15:0] mdl_mem [1024];
  logic        m_run = 1'b0;
  logic [9:0]  m_ptr = '0;
  logic [17:0] exp_q [$];
  string       tag_q [$];
  bit          finished = 0;

  function automatic logic [15:0] pat(input int i, input int g);
    return 16'((i * 40503 + g * 12345 + 17) ^ (i << 7));
  endfunction

  // Scoreboard driver: apply one reader cycle and queue its outcome.
  task automatic rd_step(input logic r, input logic p, input logic s,
                         input logic [1:0] sp, input string tag);
    logic        nrun;
    logic [9:0]  inc;
    logic [15:0] es;
    @(negedge rd_clk);
    #0.5;
    rst = r; play = p; stop = s; speed = sp;
    if (sp == 2'd0) inc = 10'd0;
    else if (sp == 2'd2) inc = 10'd2;
    else inc = 10'd1;
    if (r) begin
      nrun = 1'b0; es = '0; m_ptr = '0;
    end else begin
      nrun = s ? 1'b0 : (m_run | p);
      es   = (m_run && nrun) ? mdl_mem[m_ptr] : 16'h0;
      m_ptr = (m_run && nrun) ? m_ptr + inc : 10'd0;
    end
    m_run = nrun;
    exp_q.push_back({nrun, m_ptr[9], es});
    tag_q.push_back(tag);
  endtask

  // Monitor: compare at the falling edge after each rising edge.
  always @(negedge rd_clk) begin
    if (exp_q.size() > 0) begin
      logic [17:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      vectors++;
      if ({playing, half, sample} !== e) begin
        miscompares++;
        $display("FAIL %s: playing/half/sample = %b/%b/%h expected %b/%b/%h",
                 t, playing, half, sample, e[17], e[16], e[15:0]);
      end
    end
  end

  task automatic wr_byte(input int a, input logic [7:0] d, input logic en);
    @(negedge wr_clk);
    wr_en = en; wr_addr = 11'(a); wr_data = d;
  endtask

  task automatic wr_idle();
    @(negedge wr_clk);
    wr_en = 1'b0;
  endtask

  task automatic load_all();
    for (int i = 0; i < 1024; i++) begin
      wr_byte(2 * i,     mdl_mem[i][7:0],  1'b1);   // R6 low byte
      wr_byte(2 * i + 1, mdl_mem[i][15:8], 1'b1);   // R6 high byte
    end
    wr_byte(2 * 5, 8'hEE, 1'b0);                     // R6 disabled write
    wr_byte(2 * 5 + 1, 8'hEE, 1'b0);
    wr_idle();
  endtask

  task automatic refill_low();
    wait (half == 1'b1);
    for (int i = 0; i < 512; i++) begin
      logic [15:0] v;
      v = pat(i, 1);
      wr_byte(2 * i,     v[7:0],  1'b1);
      wr_byte(2 * i + 1, v[15:8], 1'b1);
      mdl_mem[i] = v;                                // R11 new pass data
    end
    wr_idle();
  endtask

  task automatic run_idle(input int n);
    for (int i = 0; i < n; i++) rd_step(1'b0, 1'b0, 1'b0, 2'd1, "R4");
  endtask

  task automatic run_lap();
    for (int i = 0; i < 1100; i++) begin
      if (i < 600)       rd_step(1'b0, 1'b0, 1'b0, 2'd1, "R10");
      else if (i < 1030) rd_step(1'b0, 1'b0, 1'b0, 2'd1, "R9");
      else               rd_step(1'b0, 1'b0, 1'b0, 2'd1, "R11");
    end
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mdl_mem[i] = pat(i, 0);
    rd_step(1'b1, 1'b0, 1'b0, 2'd1, "R1");
    rd_step(1'b1, 1'b0, 1'b0, 2'd1, "R1");
    fork
      run_idle(560);
      load_all();
    join
    // Start, latency, then normal streaming over the byte-mapped data.
    rd_step(1'b0, 1'b1, 1'b0, 2'd1, "R2");
    rd_step(1'b0, 1'b0, 1'b0, 2'd1, "R5");
    for (int i = 0; i < 18; i++) rd_step(1'b0, 1'b0, 1'b0, 2'd1, "R6");
    for (int i = 0; i < 4; i++)  rd_step(1'b0, 1'b0, 1'b0, 2'd0, "R8");
    for (int i = 0; i < 5; i++)  rd_step(1'b0, 1'b0, 1'b0, 2'd3, "R7");
    for (int i = 0; i < 10; i++) rd_step(1'b0, 1'b0, 1'b0, 2'd2, "R7");
    rd_step(1'b0, 1'b1, 1'b1, 2'd1, "R3");
    for (int i = 0; i < 3; i++)  rd_step(1'b0, 1'b1, 1'b1, 2'd1, "R3");
    run_idle(3);
    // Double-speed odd-offset wrap, then stop.
    rd_step(1'b0, 1'b1, 1'b0, 2'd1, "R2");
    rd_step(1'b0, 1'b0, 1'b0, 2'd1, "R5");
    for (int i = 0; i < 520; i++) rd_step(1'b0, 1'b0, 1'b0, 2'd2, "R9");
    rd_step(1'b0, 1'b0, 1'b1, 2'd1, "R3");
    // Reset while running after a restart.
    rd_step(1'b0, 1'b1, 1'b0, 2'd1, "R2");
    rd_step(1'b0, 1'b0, 1'b0, 2'd1, "R5");
    rd_step(1'b1, 1'b0, 1'b0, 2'd1, "R1");
    run_idle(2);
    // Ping-pong refill across a full lap.
    rd_step(1'b0, 1'b1, 1'b0, 2'd1, "R2");
    fork
      run_lap();
      refill_low();
    join
    rd_step(1'b0, 1'b0, 1'b1, 2'd1, "R3");
    run_idle(2);
    @(negedge rd_clk);
    @(negedge rd_clk);
    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: run did not finish, got hang expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule